// File: doc/BRIEF.md
# Bus-Master DMA Control Register Block

This block is the host-visible control face of a legacy-style bus-master DMA engine. A host reaches it over a small single-cycle register bus. Before a transfer, the host loads the base address of a descriptor table. Setting a start bit in the command register launches the transfer, and clearing that bit halts it. A status register reports whether a transfer is running, whether the system bus signalled a failure, and whether the transfer raised an interrupt.

The block drives a run level, a direction and the table base to an external transfer engine. It takes back single-cycle done and error pulses. The interrupt flag is visible on an interrupt pin. A freeze pulse masks that pin and stops the engine. A thaw pulse unmasks the pin and lets a still-active transfer run again.

Register map on the 2-bit register address: 0 is command, 1 is status, 2 is table base, 3 is reserved.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `eng_run_o` are low.
- R2: A write to address 2 stores the table base with its two lowest bits forced to zero. The stored value reads back at address 2 and appears on `eng_table_o`.
- R3: A write to address 2 while the status active bit is set is ignored, and the old base stays in place.
- R4: A command write (address 0) with bit 0 (start) set, while the stored start bit is clear, sets status bit 0 (active). `eng_run_o` then rises and `eng_dir_o` follows command bit 1 (direction).
- R5: A command write with bit 0 clear clears the start bit and the active bit and drops `eng_run_o`, without setting any flag.
- R6: A done pulse while running clears active and sets status bit 2 (interrupt). An error pulse while running clears active and sets status bit 1 (error) and bit 2 (interrupt).
- R7: Status bits 1 and 2 are write-one-to-clear. A write of zero leaves them unchanged, and a single write of 6 clears both.
- R8: Done and error pulses have no effect while the engine is not running, whether it is idle or frozen.
- R9: A freeze pulse forces `irq_o` and `eng_run_o` low and keeps the status contents. A thaw pulse restores both outputs from the kept state.
- R10: A read of reserved address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Register select |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| eng_run_o | output | 1 | Engine may transfer |
| eng_dir_o | output | 1 | Transfer direction |
| eng_table_o | output | DATA_W | Descriptor table base |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_err_i | input | 1 | Engine system-bus error pulse |
| freeze_i | input | 1 | Freeze pulse |
| thaw_i | input | 1 | Thaw pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine pulses done or error only while `eng_run_o` is high. They also assume that freeze and thaw are one-cycle pulses and never asserted together. The directed stimulus raises engine events only after a start write, or on purpose while idle or frozen to exercise R8. It pulses freeze and thaw singly. Every write re-arms a transfer by clearing the start bit first, so the start rising condition holds whenever active is expected to rise.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_TABLE = 2'd2,
    SEL_RSVD  = 2'd3
  } reg_sel_e;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 1;
  localparam int STAT_ACT_BIT  = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_IRQ_BIT  = 2;
endpackage

// File: rtl/bmdma_ctrl_regs.sv
module bmdma_ctrl_regs #(
  parameter int DATA_W    = 32,
  parameter int TBL_ALIGN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              tbl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  output logic              start_q_o,
  output logic              dir_q_o,
  output logic [DATA_W-1:0] table_q_o,
  output logic              start_set_o,
  output logic              start_clr_o
);
  import bmdma_pkg::*;

  localparam logic [DATA_W-1:0] ALIGN_MASK = DATA_W'((64'd1 << TBL_ALIGN) - 64'd1);

  assign start_set_o = cmd_we_i &  wdata_i[CMD_START_BIT] & ~start_q_o;
  assign start_clr_o = cmd_we_i & ~wdata_i[CMD_START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q_o <= 1'b0;
      dir_q_o   <= 1'b0;
      table_q_o <= '0;
    end else begin
      if (cmd_we_i) begin
        start_q_o <= wdata_i[CMD_START_BIT];
        dir_q_o   <= wdata_i[CMD_DIR_BIT];
      end
      // base is frozen while a transfer is live
      if (tbl_we_i && !active_i) table_q_o <= wdata_i & ~ALIGN_MASK;
    end
  end
endmodule

// File: rtl/bmdma_status_flags.sv
module bmdma_status_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_set_i,
  input  logic start_clr_i,
  input  logic done_ev_i,
  input  logic err_ev_i,
  input  logic w1c_err_i,
  input  logic w1c_irq_i,
  output logic active_q_o,
  output logic err_q_o,
  output logic irq_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q_o <= 1'b0;
      err_q_o    <= 1'b0;
      irq_q_o    <= 1'b0;
    end else begin
      if (start_set_i)                                active_q_o <= 1'b1;
      else if (start_clr_i || done_ev_i || err_ev_i)  active_q_o <= 1'b0;
      // engine events win over a same-cycle clear
      if (err_ev_i)       err_q_o <= 1'b1;
      else if (w1c_err_i) err_q_o <= 1'b0;
      if (done_ev_i || err_ev_i) irq_q_o <= 1'b1;
      else if (w1c_irq_i)        irq_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bmdma_freeze_ctl.sv
module bmdma_freeze_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  input  logic thaw_i,
  input  logic active_i,
  input  logic irq_i,
  output logic frozen_q_o,
  output logic run_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frozen_q_o <= 1'b0;
    else if (freeze_i) frozen_q_o <= 1'b1;
    else if (thaw_i)   frozen_q_o <= 1'b0;
  end

  assign run_o = active_i & ~frozen_q_o;
  assign irq_o = irq_i & ~frozen_q_o;
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int DATA_W    = 32,
  parameter int TBL_ALIGN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              eng_run_o,
  output logic              eng_dir_o,
  output logic [DATA_W-1:0] eng_table_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic              freeze_i,
  input  logic              thaw_i,
  output logic              irq_o
);
  import bmdma_pkg::*;

  logic              cmd_we, tbl_we, stat_we;
  logic              start_q, dir_q, start_set, start_clr;
  logic              active_q, err_q, irq_q, frozen_q;
  logic [DATA_W-1:0] table_q;
  logic              done_ev, err_ev;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(addr_i);
  assign cmd_we  = req_i & we_i & (sel == SEL_CMD);
  assign stat_we = req_i & we_i & (sel == SEL_STAT);
  assign tbl_we  = req_i & we_i & (sel == SEL_TABLE);

  // events count only while the engine is allowed to move
  assign done_ev = eng_done_i & eng_run_o;
  assign err_ev  = eng_err_i  & eng_run_o;

  bmdma_ctrl_regs #(.DATA_W(DATA_W), .TBL_ALIGN(TBL_ALIGN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .tbl_we_i    (tbl_we),
    .wdata_i     (wdata_i),
    .active_i    (active_q),
    .start_q_o   (start_q),
    .dir_q_o     (dir_q),
    .table_q_o   (table_q),
    .start_set_o (start_set),
    .start_clr_o (start_clr)
  );

  bmdma_status_flags u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_set_i (start_set),
    .start_clr_i (start_clr),
    .done_ev_i   (done_ev),
    .err_ev_i    (err_ev),
    .w1c_err_i   (stat_we & wdata_i[STAT_ERR_BIT]),
    .w1c_irq_i   (stat_we & wdata_i[STAT_IRQ_BIT]),
    .active_q_o  (active_q),
    .err_q_o     (err_q),
    .irq_q_o     (irq_q)
  );

  bmdma_freeze_ctl u_frz (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .freeze_i   (freeze_i),
    .thaw_i     (thaw_i),
    .active_i   (active_q),
    .irq_i      (irq_q),
    .frozen_q_o (frozen_q),
    .run_o      (eng_run_o),
    .irq_o      (irq_o)
  );

  assign eng_dir_o   = dir_q;
  assign eng_table_o = table_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CMD: begin
        rdata_o[CMD_START_BIT] = start_q;
        rdata_o[CMD_DIR_BIT]   = dir_q;
      end
      SEL_STAT: begin
        rdata_o[STAT_ACT_BIT] = active_q;
        rdata_o[STAT_ERR_BIT] = err_q;
        rdata_o[STAT_IRQ_BIT] = irq_q;
      end
      SEL_TABLE: rdata_o = table_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              eng_done_i,
  input logic              eng_err_i,
  input logic              freeze_i,
  input logic              irq_o,
  input logic              eng_run_o,
  input logic              start_q,
  input logic              active_q,
  input logic              err_q,
  input logic              irq_q,
  input logic [DATA_W-1:0] table_q
);
  logic cmd_wr;
  assign cmd_wr = req_i & we_i & (addr_i == 2'd0);

  AST_TABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> $stable(table_q)); // R3
  AST_START_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[0] && !start_q) |=> active_q); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !wdata_i[0]) |=> !active_q && !eng_run_o); // R5
  AST_DONE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_run_o && eng_done_i) |=> !active_q && irq_q); // R6
  AST_ERR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_run_o && eng_err_i) |=> err_q && irq_q && !active_q); // R6
  AST_FREEZE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(freeze_i) |-> !irq_o && !eng_run_o); // R9
endmodule

bind bmdma_regs bmdma_regs_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          run, dir, irq;
  logic [DW-1:0] tbl;
  logic          done = 1'b0, err = 1'b0, frz = 1'b0, thw = 1'b0;
  int            n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bmdma_regs #(.DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .eng_run_o(run), .eng_dir_o(dir),
    .eng_table_o(tbl), .eng_done_i(done), .eng_err_i(err),
    .freeze_i(frz), .thaw_i(thw), .irq_o(irq)
  );

  task automatic chk(input string req_s, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: done = 1'b1;
      1: err  = 1'b1;
      2: frz  = 1'b1;
      default: thw = 1'b1;
    endcase
    @(negedge clk); done = 1'b0; err = 1'b0; frz = 1'b0; thw = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v); chk("R1 reg", v, '0);
    end
    chk("R1 irq", DW'(irq), '0);
    chk("R1 run", DW'(run), '0);
  endtask

  task automatic t_table;
    logic [DW-1:0] v;
    wr(2'd2, 32'h1234_567F);
    rd(2'd2, v); chk("R2 readback", v, 32'h1234_567C);
    chk("R2 engine base", tbl, 32'h1234_567C);
    wr(2'd0, 32'h1);
    wr(2'd2, 32'hAAAA_0000);
    rd(2'd2, v); chk("R3 locked base", v, 32'h1234_567C);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0000_1000);
    rd(2'd2, v); chk("R3 unlocked base", v, 32'h0000_1000);
  endtask

  task automatic t_start_stop;
    logic [DW-1:0] v;
    wr(2'd0, 32'h3);
    rd(2'd1, v); chk("R4 active", v, 32'h1);
    chk("R4 run", DW'(run), 32'h1);
    chk("R4 dir", DW'(dir), 32'h1);
    wr(2'd0, 32'h0);
    rd(2'd1, v); chk("R5 status", v, 32'h0);
    chk("R5 run", DW'(run), '0);
    wr(2'd0, 32'h1);
    chk("R4 dir low", DW'(dir), '0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_events;
    logic [DW-1:0] v;
    wr(2'd0, 32'h1);
    pulse(0);
    rd(2'd1, v); chk("R6 done", v, 32'h4);
    chk("R6 irq pin", DW'(irq), 32'h1);
    chk("R6 run off", DW'(run), '0);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R7 zero write", v, 32'h4);
    wr(2'd1, 32'h4);
    rd(2'd1, v); chk("R7 clear irq", v, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h1);
    pulse(1);
    rd(2'd1, v); chk("R6 error", v, 32'h6);
    wr(2'd1, 32'h2);
    rd(2'd1, v); chk("R7 clear err only", v, 32'h4);
    wr(2'd1, 32'h6);
    rd(2'd1, v); chk("R7 clear both", v, 32'h0);
    wr(2'd0, 32'h0);
    pulse(0); pulse(1);
    rd(2'd1, v); chk("R8 idle events", v, 32'h0);
  endtask

  task automatic t_freeze;
    logic [DW-1:0] v;
    wr(2'd0, 32'h1);
    pulse(2);
    chk("R9 run frozen", DW'(run), '0);
    pulse(0);
    rd(2'd1, v); chk("R8 frozen done", v, 32'h1);
    pulse(3);
    chk("R9 run thawed", DW'(run), 32'h1);
    pulse(0);
    chk("R9 irq before", DW'(irq), 32'h1);
    pulse(2);
    chk("R9 irq masked", DW'(irq), '0);
    rd(2'd1, v); chk("R9 status kept", v, 32'h4);
    pulse(3);
    chk("R9 irq restored", DW'(irq), 32'h1);
    wr(2'd1, 32'h6);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_rsvd;
    logic [DW-1:0] v;
    wr(2'd2, 32'hFFFF_FFF0);
    rd(2'd3, v); chk("R10 reserved", v, '0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_table();
    t_start_stop();
    t_events();
    t_freeze();
    t_rsvd();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule